// File: doc/BRIEF.md
# Gated System-Management Interrupt Aggregator

This block collects single-cycle event pulses from a number of sources into sticky status bits. Each status register has a matching enable register. The enabled, pending bits are combined into one group interrupt. A master enable bit in a control register gates that group. The result drives a single active-low interrupt pin.

The pin driver can run in one of two modes: open-drain or push-pull. When the interrupt is asserted, the pin is driven low in either mode. When it is not asserted, an open-drain pin releases the line (the output enable is low), while a push-pull pin drives it high. Software uses a small register port to read status, clear status bits by writing 1 to them, and program the enables and the control register. Status bits can be given a preset power-on value, so chosen bits come out of reset already set.

The pin driver is a three-state machine. `PIN_FLOAT` is the open-drain idle state, `PIN_HIGH` is the push-pull idle state, and `PIN_DRIVE_LOW` is the asserted state. Every clock it moves to `PIN_DRIVE_LOW` when the master enable and the group interrupt are both true. Otherwise it moves to `PIN_HIGH` if push-pull is selected, or to `PIN_FLOAT` if it is not. It can therefore go directly from any state to any other: assert (idle to `PIN_DRIVE_LOW`), release (`PIN_DRIVE_LOW` to an idle state), or change mode (between the two idle states). The pin follows the internal state one clock later, because of the state register.

Top module: `smi_aggregator`

## Requirements
- R1: During and after reset, every status bit equals its entry in `STS_INIT` (default: only bit 2 of status register 0 set), all enable registers are 0, the control register is 0, and the pin is in `PIN_FLOAT` (`pin_oe`=0, `pin_out`=1).
- R2: An event pulse on `evt_pulse[r*REG_W+b]` sets bit b of status register r on the next clock edge. The bit then stays set when the pulse ends.
- R3: Writing status register r (address r) clears each bit whose write-data bit is 1. Bits written with 0 keep their value.
- R4: When an event pulse and a write-1-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R5: The group interrupt is the OR of every status bit ANDed with its enable bit. Enable register r is at address NUM_REGS+r. If the group interrupt and the master enable are both true, the pin is driven low (`pin_oe`=1, `pin_out`=0) one clock later.
- R6: While the master enable (control bit 7) is 0, the pin is never driven low, whatever the status and enables hold.
- R7: With control bit 0 = 0 (open-drain), the inactive pin is released: `pin_oe`=0.
- R8: With control bit 0 = 1 (push-pull), the inactive pin is driven high: `pin_oe`=1, `pin_out`=1.
- R9: Enable registers read back the value written. The control register (address 2*NUM_REGS) keeps and returns only bits 7 and 0; all its other bits read 0.
- R10: A change to status, enables or control reaches the pin exactly one clock after the edge that stores it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_pulse | input | NUM_REGS*REG_W | One-cycle event pulses, one per status bit |
| reg_addr | input | ADDR_W | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | REG_W | Write data |
| reg_rdata | output | REG_W | Read data for `reg_addr` (combinational) |
| pin_out | output | 1 | Pin output level (active low) |
| pin_oe | output | 1 | Pin output-buffer enable |

## Verification
The bench checks that a write-1-to-clear in the same cycle as an event leaves the bit set. A design that let the clear win would lose that event, and the pin would release while a source was still pending. It writes zeros to a pending bit to catch a clear path that ignores the mask. It drops the master enable while an enabled bit is pending: a missing gate would keep the pin low. It switches the driver mode in both directions. If the two idle levels were swapped, the pin would show `pin_oe` low in push-pull mode, or a driven high level in open-drain mode. Every pin check is made at the exact clock the single state register allows, so one extra stage, or one missing stage, causes a failure.

// File: rtl/smi_agg_pkg.sv
package smi_agg_pkg;

    typedef enum logic [1:0] {
        PIN_FLOAT     = 2'd0,
        PIN_HIGH      = 2'd1,
        PIN_DRIVE_LOW = 2'd2
    } pin_state_e;

    localparam int CTRL_MASTER_BIT = 7;
    localparam int CTRL_PP_BIT     = 0;

endpackage

// File: rtl/smi_status_bank.sv
module smi_status_bank #(
    parameter int                REG_W    = 8,
    parameter logic [REG_W-1:0]  STS_INIT = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] evt,
    input  logic             sts_we,
    input  logic             en_we,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] sts,
    output logic [REG_W-1:0] en,
    output logic             hit
);

    logic [REG_W-1:0] clr_mask;

    assign clr_mask = sts_we ? wdata : '0;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts <= STS_INIT;
        end else begin
            sts <= (sts & ~clr_mask) | evt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en <= '0;
        end else if (en_we) begin
            en <= wdata;
        end
    end

    assign hit = |(sts & en);

endmodule

// File: rtl/smi_pin_fsm.sv
module smi_pin_fsm
    import smi_agg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic group_irq,
    input  logic master_en,
    input  logic push_pull,
    output logic pin_out,
    output logic pin_oe
);

    pin_state_e state_q;
    pin_state_e state_d;

    always_comb begin
        if (master_en && group_irq) begin
            state_d = PIN_DRIVE_LOW;
        end else if (push_pull) begin
            state_d = PIN_HIGH;
        end else begin
            state_d = PIN_FLOAT;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PIN_FLOAT;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            PIN_FLOAT: begin
                pin_oe  = 1'b0;
                pin_out = 1'b1;
            end
            PIN_HIGH: begin
                pin_oe  = 1'b1;
                pin_out = 1'b1;
            end
            PIN_DRIVE_LOW: begin
                pin_oe  = 1'b1;
                pin_out = 1'b0;
            end
            default: begin
                pin_oe  = 1'b0;
                pin_out = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/smi_aggregator.sv
module smi_aggregator
    import smi_agg_pkg::*;
#(
    parameter int                          NUM_REGS = 2,
    parameter int                          REG_W    = 8,
    parameter logic [NUM_REGS*REG_W-1:0]   STS_INIT = 16'h0004,
    localparam int                         ADDR_W   = $clog2(2*NUM_REGS+1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_REGS*REG_W-1:0] evt_pulse,
    input  logic [ADDR_W-1:0]         reg_addr,
    input  logic                      reg_wr,
    input  logic [REG_W-1:0]          reg_wdata,
    output logic [REG_W-1:0]          reg_rdata,
    output logic                      pin_out,
    output logic                      pin_oe
);

    localparam int CTRL_ADDR = 2*NUM_REGS;

    logic [REG_W-1:0]          sts_arr [NUM_REGS];
    logic [REG_W-1:0]          en_arr  [NUM_REGS];
    logic [NUM_REGS-1:0]       hit_vec;
    logic [NUM_REGS*REG_W-1:0] sts_all;
    logic                      group_irq;
    logic                      master_en;
    logic                      drive_pp;
    logic                      ctrl_we;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_bank
        logic sts_we_g;
        logic en_we_g;
        assign sts_we_g = reg_wr && (reg_addr == ADDR_W'(g));
        assign en_we_g  = reg_wr && (reg_addr == ADDR_W'(NUM_REGS + g));

        smi_status_bank #(
            .REG_W    (REG_W),
            .STS_INIT (STS_INIT[g*REG_W +: REG_W])
        ) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .evt    (evt_pulse[g*REG_W +: REG_W]),
            .sts_we (sts_we_g),
            .en_we  (en_we_g),
            .wdata  (reg_wdata),
            .sts    (sts_arr[g]),
            .en     (en_arr[g]),
            .hit    (hit_vec[g])
        );

        assign sts_all[g*REG_W +: REG_W] = sts_arr[g];
    end

    assign group_irq = |hit_vec;
    assign ctrl_we   = reg_wr && (reg_addr == ADDR_W'(CTRL_ADDR));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            master_en <= 1'b0;
            drive_pp  <= 1'b0;
        end else if (ctrl_we) begin
            master_en <= reg_wdata[CTRL_MASTER_BIT];
            drive_pp  <= reg_wdata[CTRL_PP_BIT];
        end
    end

    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (reg_addr == ADDR_W'(i)) begin
                reg_rdata = sts_arr[i];
            end
            if (reg_addr == ADDR_W'(NUM_REGS + i)) begin
                reg_rdata = en_arr[i];
            end
        end
        if (reg_addr == ADDR_W'(CTRL_ADDR)) begin
            reg_rdata[CTRL_MASTER_BIT] = master_en;
            reg_rdata[CTRL_PP_BIT]     = drive_pp;
        end
    end

    smi_pin_fsm u_pin (
        .clk       (clk),
        .rst_n     (rst_n),
        .group_irq (group_irq),
        .master_en (master_en),
        .push_pull (drive_pp),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe)
    );

endmodule

// File: rtl/smi_aggregator_chk.sv
module smi_aggregator_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] evt_pulse,
    input logic [W-1:0] sts_all,
    input logic         group_irq,
    input logic         master_en,
    input logic         drive_pp,
    input logic         pin_out,
    input logic         pin_oe
);

    // R2
    evt_sets_sts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|evt_pulse) |=> ((sts_all & $past(evt_pulse)) == $past(evt_pulse)));

    // R3
    no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((sts_all & ~$past(sts_all) & ~$past(evt_pulse)) == '0));

    // R5
    assert_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (master_en && group_irq) |=> (pin_oe && !pin_out));

    // R6
    master_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !master_en |=> !(pin_oe && !pin_out));

    // R7
    float_only_od_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_oe |-> !$past(drive_pp));

    // R8
    high_only_pp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe && pin_out) |-> $past(drive_pp));

endmodule

bind smi_aggregator smi_aggregator_chk #(.W(NUM_REGS*REG_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_pulse (evt_pulse),
    .sts_all   (sts_all),
    .group_irq (group_irq),
    .master_en (master_en),
    .drive_pp  (drive_pp),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe)
);

// File: tb/test_smi_aggregator.sv
module test_smi_aggregator;

    localparam int NREG = 2;
    localparam int RW   = 8;
    localparam int AW   = $clog2(2*NREG+1);

    typedef struct {
        logic  oe;
        logic  out;
        string tag;
    } pin_item_t;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NREG*RW-1:0] evt_pulse = '0;
    logic [AW-1:0]    reg_addr = '0;
    logic             reg_wr = 1'b0;
    logic [RW-1:0]    reg_wdata = '0;
    logic [RW-1:0]    reg_rdata;
    logic             pin_out;
    logic             pin_oe;

    int        n_tests = 0;
    int        n_fail  = 0;
    bit        done    = 1'b0;
    pin_item_t sb[$];

    always #10 clk = ~clk;

    smi_aggregator i_smi_aggregator (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_pulse (evt_pulse),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe)
    );

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // monitor: pops one expected pin item per clock, just after the edge
    always @(posedge clk) begin
        #2;
        if (sb.size() > 0) begin
            pin_item_t it;
            it = sb.pop_front();
            check(it.tag, {6'd0, pin_oe, pin_out}, {6'd0, it.oe, it.out});
        end
    end

    // driver helpers: inputs change on the falling edge
    task automatic expect_pin(logic oe, logic out, string tag);
        pin_item_t it;
        it.oe = oe; it.out = out; it.tag = tag;
        sb.push_back(it);
        @(negedge clk);
        reg_wr    = 1'b0;
        evt_pulse = '0;
    endtask

    task automatic wr_op(int a, logic [7:0] d, logic [NREG*RW-1:0] e);
        reg_addr  = AW'(a);
        reg_wdata = d;
        reg_wr    = 1'b1;
        evt_pulse = e;
    endtask

    task automatic ev_op(logic [NREG*RW-1:0] e);
        reg_wr    = 1'b0;
        evt_pulse = e;
    endtask

    task automatic rd_check(int a, logic [7:0] exp, string tag);
        reg_wr   = 1'b0;
        reg_addr = AW'(a);
        #1;
        check(tag, reg_rdata, exp);
    endtask

    localparam logic [NREG*RW-1:0] EV9 = 16'h0200;

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 pin during reset", {6'd0, pin_oe, pin_out}, 8'h01);
        rst_n = 1'b1;
        rd_check(0, 8'h04, "R1 status0 preset");
        rd_check(1, 8'h00, "R1 status1");
        rd_check(2, 8'h00, "R1 enable0");
        rd_check(4, 8'h00, "R1 control");
        expect_pin(1'b0, 1'b1, "R1 pin after reset");

        // enable pending bit with master off: R6
        wr_op(2, 8'h04, '0);
        expect_pin(1'b0, 1'b1, "R6 master off a");
        expect_pin(1'b0, 1'b1, "R6 master off b");

        // master on, open-drain: R5/R10
        wr_op(4, 8'h80, '0);
        expect_pin(1'b0, 1'b1, "R10 one-cycle lag");
        expect_pin(1'b1, 1'b0, "R5 assert open-drain");

        // clear pending bit: R3, R7
        wr_op(0, 8'h04, '0);
        expect_pin(1'b1, 1'b0, "R10 release lag");
        expect_pin(1'b0, 1'b1, "R7 open-drain idle floats");
        rd_check(0, 8'h00, "R3 status0 cleared");

        // switch to push-pull: R8
        wr_op(4, 8'h81, '0);
        expect_pin(1'b0, 1'b1, "R10 mode change lag");
        expect_pin(1'b1, 1'b1, "R8 push-pull idle high");

        // event on reg1 bit1, not enabled: R2
        ev_op(EV9);
        expect_pin(1'b1, 1'b1, "R5 disabled event a");
        expect_pin(1'b1, 1'b1, "R5 disabled event b");
        rd_check(1, 8'h02, "R2 sticky status1");

        // enable it: R5, R9
        wr_op(3, 8'h02, '0);
        expect_pin(1'b1, 1'b1, "R10 enable lag");
        expect_pin(1'b1, 1'b0, "R5 assert push-pull");
        rd_check(3, 8'h02, "R9 enable1 readback");

        // write zero: no clear: R3
        wr_op(1, 8'h00, '0);
        expect_pin(1'b1, 1'b0, "R3 zero write a");
        expect_pin(1'b1, 1'b0, "R3 zero write b");
        rd_check(1, 8'h02, "R3 zero write keeps bit");

        // clear and set same cycle: R4
        wr_op(1, 8'h02, EV9);
        expect_pin(1'b1, 1'b0, "R4 collision a");
        expect_pin(1'b1, 1'b0, "R4 collision b");
        rd_check(1, 8'h02, "R4 set wins");

        // real clear
        wr_op(1, 8'h02, '0);
        expect_pin(1'b1, 1'b0, "R10 clear lag");
        expect_pin(1'b1, 1'b1, "R8 released high");
        rd_check(1, 8'h00, "R3 status1 cleared");

        // re-raise, then drop master while pending: R6
        ev_op(EV9);
        expect_pin(1'b1, 1'b1, "R10 event lag");
        expect_pin(1'b1, 1'b0, "R5 re-assert");
        wr_op(4, 8'h01, '0);
        expect_pin(1'b1, 1'b0, "R10 master lag");
        expect_pin(1'b1, 1'b1, "R6 gated push-pull");
        wr_op(4, 8'h00, '0);
        expect_pin(1'b1, 1'b1, "R10 mode lag");
        expect_pin(1'b0, 1'b1, "R7 gated open-drain");

        // control readback masking: R9
        wr_op(4, 8'hFF, '0);
        expect_pin(1'b0, 1'b1, "R10 ctrl lag");
        rd_check(4, 8'h81, "R9 control readback");
        expect_pin(1'b1, 1'b0, "R5 assert after ctrl");

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule